// File: doc/BRIEF.md
# Pointwise Int8 Convolution Engine

This block computes a 1x1 two-dimensional convolution over signed 8-bit activations and weights. Every step takes one activation tile and one weight tile. The activation tile holds 4 neighbouring pixels of one row, each with 8 input channels. The weight tile holds an 8 x 8 block of input and output channels. The block multiplies the two tiles and adds the results into 32 signed 32-bit accumulators, one for each pixel and output channel. When the last input-channel group of a tile has been taken, the accumulators are presented on the output stream as one 4-pixel by 8-output-channel result.

Software pulses `start` together with the feature-map width and height and the number of input and output channel groups. The group counts are channel counts divided by 8, so both channel counts must be multiples of 8. All four configuration values must be at least 1. An upstream fetcher reads the channels-last grouped layouts from memory and presents the tiles in the block's step order. Pixels beyond the configured width, in the last tile of a row, produce zero whatever data arrives in their lanes. This covers widths that are not a multiple of 4. The block pulses `done` once the final result tile has been taken downstream.

Top module: `pw_conv_engine`

## Requirements
- R1: After reset, `out_valid`, `act_ready`, `wgt_ready` and `done` are all low.
- R2: Each result lane is the exact signed sum, over every input channel, of activation x weight for its pixel and output channel. Lane (pixel p, output channel o) sits at `out_data[(p*8+o)*32 +: 32]`. Activation byte (p, c) sits at `act_data[(p*8+c)*8 +: 8]`. Weight byte (input i, output o) sits at `wgt_data[(i*8+o)*8 +: 8]`.
- R3: Steps are taken in this order: row (outermost), then X tile of 4 pixels, then output group, then input group (innermost). One activation tile and one weight tile are taken together, on an edge where both valids are high and both readies are high.
- R4: The accumulators start again at the first input group of every result tile, so nothing carries over from the previous tile.
- R5: Lane p of a tile whose first pixel is at X = x yields zero when x + p is not less than the configured width, whatever the activation data in that lane.
- R6: `out_valid` rises on the edge that takes the last input-group step of a tile. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold steady and both input readies stay low.
- R7: `done` is high for exactly one cycle, and that cycle follows the edge on which the final result tile is taken. It is low at all other times.
- R8: A `start` pulse that arrives while a run is in progress is ignored, together with the configuration that comes with it.
- R9: Accumulation is exact at the int8 extremes. For example, 32 input channels of (-128)x(-128) yield 524288, and 32 input channels of 127x(-128) yield -520192.
- R10: While no run is feeding, both input readies stay low, even when the inputs are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| cfg_width | input | 12 | Feature-map width in pixels |
| cfg_height | input | 12 | Feature-map height in rows |
| cfg_cin_grp | input | 6 | Input channels divided by 8 |
| cfg_cout_grp | input | 6 | Output channels divided by 8 |
| act_valid | input | 1 | Activation tile present |
| act_ready | output | 1 | Activation tile taken this edge |
| act_data | input | 256 | 4 pixels x 8 channels of int8 |
| wgt_valid | input | 1 | Weight tile present |
| wgt_ready | output | 1 | Weight tile taken this edge |
| wgt_data | input | 512 | 8 input x 8 output channels of int8 |
| out_valid | output | 1 | Result tile present |
| out_ready | input | 1 | Downstream takes the result tile |
| out_data | output | 1024 | 4 pixels x 8 output channels of int32 |
| done | output | 1 | One-cycle pulse after the last result is taken |

## Verification
A result tile is due one edge after the step that carries its last input group. The bench therefore drives its inputs and its random `out_ready` at the falling edge, waits one time unit, and judges `out_valid` and `out_data` there. It decides each transfer from the readies it sees at that moment, and those readies cannot change before the next rising edge. `done` is due at the sample that follows the final output handshake and must be gone one sample later. A stalled output is compared at each following sample with the value it held before.

// File: rtl/pw_conv_pkg.sv
package pw_conv_pkg;

   // Smallest accumulator that cannot overflow: one product, the adds of
   // one group, and the adds across up to 2**gw groups.
   function automatic int unsigned acc_bits_needed(input int unsigned dw,
                                                   input int unsigned ch,
                                                   input int unsigned gw);
      return 2 * dw + $clog2(ch) + gw;
   endfunction

endpackage

// File: rtl/pw_seq.sv
module pw_seq #(
   parameter int PIX  = 4,
   parameter int DIMW = 12,
   parameter int GW   = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [DIMW-1:0] cfg_width,
   input  logic [DIMW-1:0] cfg_height,
   input  logic [GW-1:0]   cfg_cin_grp,
   input  logic [GW-1:0]   cfg_cout_grp,
   input  logic            fire,
   input  logic            out_take,
   output logic            feeding,
   output logic            first_grp,
   output logic            last_grp,
   output logic [PIX-1:0]  lane_en,
   output logic            done
);
   localparam int XW = DIMW + 1;

   logic            busy;
   logic [DIMW-1:0] w_q, h_q, row_q;
   logic [GW-1:0]   ci_q, co_q, ig_q, og_q;
   logic [XW-1:0]   xb_q, xb_nx;
   logic            last_og, last_x, last_row;

   assign xb_nx     = xb_q + XW'(PIX);
   assign last_grp  = (ig_q == ci_q - GW'(1));
   assign last_og   = (og_q == co_q - GW'(1));
   assign last_x    = (xb_nx >= {1'b0, w_q});
   assign last_row  = (row_q == h_q - DIMW'(1));
   assign first_grp = (ig_q == '0);

   for (genvar gp = 0; gp < PIX; gp++) begin : g_mask
      assign lane_en[gp] = ((xb_q + XW'(gp)) < {1'b0, w_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; feeding <= 1'b0; done <= 1'b0;
         w_q <= '0; h_q <= '0; ci_q <= '0; co_q <= '0;
         ig_q <= '0; og_q <= '0; xb_q <= '0; row_q <= '0;
      end else begin
         done <= 1'b0;
         if (!busy && start) begin
            w_q  <= cfg_width;   h_q  <= cfg_height;
            ci_q <= cfg_cin_grp; co_q <= cfg_cout_grp;
            ig_q <= '0; og_q <= '0; xb_q <= '0; row_q <= '0;
            busy <= 1'b1; feeding <= 1'b1;
         end
         if (fire) begin
            if (!last_grp) begin
               ig_q <= ig_q + GW'(1);
            end else begin
               ig_q <= '0;
               if (!last_og) begin
                  og_q <= og_q + GW'(1);
               end else begin
                  og_q <= '0;
                  if (!last_x) begin
                     xb_q <= xb_nx;
                  end else begin
                     xb_q <= '0;
                     if (!last_row) begin
                        row_q <= row_q + DIMW'(1);
                     end else begin
                        row_q   <= '0;
                        feeding <= 1'b0;
                     end
                  end
               end
            end
         end
         if (busy && !feeding && out_take) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end

   // R10: no step is taken unless a run is feeding
   a_r10_no_step_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !feeding |-> !fire);
   // R7: done never lasts two cycles
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: done follows an output handshake
   a_r7_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_take));
   // R8: a start during a run leaves the latched configuration alone
   a_r8_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(w_q) && $stable(h_q) && $stable(ci_q) && $stable(co_q)));
endmodule

// File: rtl/pw_mac_tile.sv
module pw_mac_tile #(
   parameter int PIX = 4,
   parameter int CH  = 8,
   parameter int DW  = 8,
   parameter int AW  = 32
) (
   input  logic [PIX*CH*DW-1:0] act_data,
   input  logic [CH*CH*DW-1:0]  wgt_data,
   input  logic [PIX-1:0]       lane_en,
   output logic [PIX*CH*AW-1:0] mac_sum
);
   localparam int PW = 2 * DW;

   for (genvar gp = 0; gp < PIX; gp++) begin : g_pix
      for (genvar go = 0; go < CH; go++) begin : g_och
         logic signed [AW-1:0] s;
         logic signed [PW-1:0] ae, we, pr;
         always_comb begin
            s  = '0;
            ae = '0;
            we = '0;
            pr = '0;
            for (int i = 0; i < CH; i++) begin
               ae = lane_en[gp]
                  ? {{DW{act_data[(gp*CH+i)*DW+DW-1]}}, act_data[(gp*CH+i)*DW +: DW]}
                  : '0;
               we = {{DW{wgt_data[(i*CH+go)*DW+DW-1]}}, wgt_data[(i*CH+go)*DW +: DW]};
               pr = ae * we;
               s  = s + {{(AW-PW){pr[PW-1]}}, pr};
            end
         end
         assign mac_sum[(gp*CH+go)*AW +: AW] = s;
      end
   end
endmodule

// File: rtl/pw_acc.sv
module pw_acc #(
   parameter int PIX = 4,
   parameter int CH  = 8,
   parameter int AW  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fire,
   input  logic                 first_grp,
   input  logic                 last_grp,
   input  logic [PIX*CH*AW-1:0] mac_sum,
   input  logic                 out_ready,
   output logic                 out_valid,
   output logic [PIX*CH*AW-1:0] out_data
);
   localparam int LANES = PIX * CH;

   for (genvar gl = 0; gl < LANES; gl++) begin : g_acc
      logic [AW-1:0] q, base;
      assign base = first_grp ? '0 : q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= '0;
         else if (fire) q <= base + mac_sum[gl*AW +: AW];
      end
      assign out_data[gl*AW +: AW] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                out_valid <= 1'b0;
      else if (fire && last_grp) out_valid <= 1'b1;
      else if (out_ready)        out_valid <= 1'b0;
   end

   // R6: a result waiting on downstream stays put
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pw_conv_engine.sv
module pw_conv_engine
   import pw_conv_pkg::*;
#(
   parameter int PIX  = 4,
   parameter int CH   = 8,
   parameter int DW   = 8,
   parameter int AW   = 32,
   parameter int DIMW = 12,
   parameter int GW   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [DIMW-1:0]      cfg_width,
   input  logic [DIMW-1:0]      cfg_height,
   input  logic [GW-1:0]        cfg_cin_grp,
   input  logic [GW-1:0]        cfg_cout_grp,
   input  logic                 act_valid,
   output logic                 act_ready,
   input  logic [PIX*CH*DW-1:0] act_data,
   input  logic                 wgt_valid,
   output logic                 wgt_ready,
   input  logic [CH*CH*DW-1:0]  wgt_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [PIX*CH*AW-1:0] out_data,
   output logic                 done
);
   if (PIX < 1 || CH < 1 || DW < 2 || DIMW < 2 || GW < 1) begin : g_bad_dims
      $error("pw_conv_engine: dimension parameters out of range");
   end
   if (AW < acc_bits_needed(DW, CH, GW)) begin : g_bad_aw
      $error("pw_conv_engine: accumulator width too small");
   end

   logic           feeding, first_grp, last_grp, can_step, fire, out_take;
   logic [PIX-1:0] lane_en;
   logic [PIX*CH*AW-1:0] mac_sum;

   assign can_step  = feeding && (!out_valid || out_ready);
   assign act_ready = can_step && wgt_valid;
   assign wgt_ready = can_step && act_valid;
   assign fire      = can_step && act_valid && wgt_valid;
   assign out_take  = out_valid && out_ready;

   pw_seq #(.PIX(PIX), .DIMW(DIMW), .GW(GW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_width(cfg_width), .cfg_height(cfg_height),
      .cfg_cin_grp(cfg_cin_grp), .cfg_cout_grp(cfg_cout_grp),
      .fire(fire), .out_take(out_take), .feeding(feeding),
      .first_grp(first_grp), .last_grp(last_grp),
      .lane_en(lane_en), .done(done));

   pw_mac_tile #(.PIX(PIX), .CH(CH), .DW(DW), .AW(AW)) u_mac (
      .act_data(act_data), .wgt_data(wgt_data),
      .lane_en(lane_en), .mac_sum(mac_sum));

   pw_acc #(.PIX(PIX), .CH(CH), .AW(AW)) u_acc (
      .clk(clk), .rst_n(rst_n), .fire(fire),
      .first_grp(first_grp), .last_grp(last_grp), .mac_sum(mac_sum),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data));

   // R3: the two tiles of a step always move together
   a_r3_joint_take: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && act_ready) |-> (wgt_valid && wgt_ready));
   // R6: nothing is taken in while a result is stalled
   a_r6_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> (!act_ready && !wgt_ready));
endmodule

// File: tb/sim_pw_conv_engine.sv
module sim_pw_conv_engine;
   localparam int PIX = 4, CH = 8, DW = 8, AW = 32, DIMW = 12, GW = 6;
   localparam int OW = PIX * CH * AW;
   localparam int NCASE = 9;
   // width, height, input groups, output groups, data mode, restart attempt
   localparam int CASES [0:NCASE-1][0:5] = '{
      '{4, 1, 1, 1, 0, 0}, '{8, 2, 2, 2, 0, 0}, '{6, 1, 3, 1, 0, 0},
      '{5, 2, 1, 2, 0, 1}, '{12, 1, 4, 3, 0, 0}, '{3, 3, 2, 1, 0, 0},
      '{4, 1, 4, 2, 1, 0}, '{7, 1, 4, 1, 2, 0}, '{1, 2, 1, 1, 0, 0}};

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [DIMW-1:0] cfg_width = '0, cfg_height = '0;
   logic [GW-1:0]   cfg_cin_grp = '0, cfg_cout_grp = '0;
   logic act_valid = 1'b0, wgt_valid = 1'b0, out_ready = 1'b0;
   logic act_ready, wgt_ready, out_valid, done;
   logic [PIX*CH*DW-1:0] act_data = '0;
   logic [CH*CH*DW-1:0]  wgt_data = '0;
   logic [OW-1:0]        out_data;
   int n_chk = 0, n_bad = 0;

   pw_conv_engine #(.PIX(PIX), .CH(CH), .DW(DW), .AW(AW), .DIMW(DIMW), .GW(GW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
      .cfg_height(cfg_height), .cfg_cin_grp(cfg_cin_grp), .cfg_cout_grp(cfg_cout_grp),
      .act_valid(act_valid), .act_ready(act_ready), .act_data(act_data),
      .wgt_valid(wgt_valid), .wgt_ready(wgt_ready), .wgt_data(wgt_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done));

   always #10 clk = ~clk;   // 20 ns period, 50 MHz

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [OW-1:0] got, input logic [OW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic int act_val(int mode, int seed, int row, int x, int c);
      if (mode == 1) return -128;
      if (mode == 2) return 127;
      return ((row * 37 + x * 11 + c * 5 + seed * 13) * 29 + 7) % 256 - 128;
   endfunction

   function automatic int wgt_val(int mode, int seed, int o, int i);
      if (mode != 0) return -128;
      return ((o * 19 + i * 23 + seed * 7) * 31 + 3) % 256 - 128;
   endfunction

   function automatic logic [PIX*CH*DW-1:0] act_tile(int mode, int seed, int row, int xb, int ig);
      logic [PIX*CH*DW-1:0] t;
      int v;
      t = '0;
      for (int p = 0; p < PIX; p++)
         for (int c = 0; c < CH; c++) begin
            v = act_val(mode, seed, row, xb + p, ig * CH + c);
            t[(p*CH+c)*DW +: DW] = v[DW-1:0];
         end
      return t;
   endfunction

   function automatic logic [CH*CH*DW-1:0] wgt_tile(int mode, int seed, int og, int ig);
      logic [CH*CH*DW-1:0] t;
      int v;
      t = '0;
      for (int i = 0; i < CH; i++)
         for (int o = 0; o < CH; o++) begin
            v = wgt_val(mode, seed, og * CH + o, ig * CH + i);
            t[(i*CH+o)*DW +: DW] = v[DW-1:0];
         end
      return t;
   endfunction

   function automatic logic [OW-1:0] exp_tile(int mode, int seed, int w, int cig,
                                              int row, int xb, int og);
      logic [OW-1:0] t;
      int s;
      t = '0;
      for (int p = 0; p < PIX; p++)
         for (int o = 0; o < CH; o++) begin
            s = 0;
            if (xb + p < w)
               for (int ci = 0; ci < cig * CH; ci++)
                  s += act_val(mode, seed, row, xb + p, ci) * wgt_val(mode, seed, og * CH + o, ci);
            t[(p*CH+o)*AW +: AW] = s;
         end
      return t;
   endfunction

   // R3: tiles are offered in row, X tile, output group, input group order
   task automatic feed_act(int w, int h, int cig, int cog, int mode, int seed);
      bit got;
      for (int row = 0; row < h; row++)
         for (int xb = 0; xb < w; xb += PIX)
            for (int og = 0; og < cog; og++)
               for (int ig = 0; ig < cig; ig++) begin
                  got = 1'b0;
                  while (!got) begin
                     @(negedge clk);
                     if ($urandom % 4 == 0) act_valid = 1'b0;
                     else begin
                        act_valid = 1'b1;
                        act_data  = act_tile(mode, seed, row, xb, ig);
                        #1 got = act_ready;
                     end
                  end
               end
      @(negedge clk);
      act_valid = 1'b0;
   endtask

   task automatic feed_wgt(int w, int h, int cig, int cog, int mode, int seed);
      bit got;
      for (int row = 0; row < h; row++)
         for (int xb = 0; xb < w; xb += PIX)
            for (int og = 0; og < cog; og++)
               for (int ig = 0; ig < cig; ig++) begin
                  got = 1'b0;
                  while (!got) begin
                     @(negedge clk);
                     if ($urandom % 3 == 0) wgt_valid = 1'b0;
                     else begin
                        wgt_valid = 1'b1;
                        wgt_data  = wgt_tile(mode, seed, og, ig);
                        #1 got = wgt_ready;
                     end
                  end
               end
      @(negedge clk);
      wgt_valid = 1'b0;
   endtask

   task automatic drain(int w, int h, int cig, int cog, int mode, int seed, bit rs);
      bit prev_stall, taken, seen;
      logic [OW-1:0] prev, exp;
      string tag;
      prev_stall = 1'b0;
      prev = '0;
      for (int row = 0; row < h; row++)
         for (int xb = 0; xb < w; xb += PIX)
            for (int og = 0; og < cog; og++) begin
               taken = 1'b0;
               seen  = 1'b0;
               if (mode != 0)        tag = "R9";
               else if (rs)          tag = "R8";
               else if (xb + PIX > w) tag = "R5";
               else                  tag = "R2,R4";
               exp = exp_tile(mode, seed, w, cig, row, xb, og);
               while (!taken) begin
                  @(negedge clk);
                  out_ready = ($urandom % 3) != 0;
                  #1;
                  if (prev_stall)
                     check(out_valid && out_data == prev, "R6", "held result", out_data, prev);
                  if (out_valid && !out_ready)
                     check(!act_ready && !wgt_ready, "R6", "intake during stall",
                           OW'({act_ready, wgt_ready}), '0);
                  if (out_valid && !seen) begin
                     check(out_data == exp, tag, "result tile", out_data, exp);
                     check(!done, "R7", "done before end", OW'(done), '0);
                     seen = 1'b1;
                  end
                  prev_stall = out_valid && !out_ready;
                  prev       = out_data;
                  taken      = out_valid && out_ready;
               end
            end
      @(negedge clk);
      out_ready = 1'b0;
      #1 check(done == 1'b1, "R7", "done after last take", OW'(done), OW'(1));
      @(negedge clk);
      #1 check(done == 1'b0, "R7", "done one cycle", OW'(done), '0);
   endtask

   task automatic restart_try();
      logic [DIMW-1:0] sw;
      logic [GW-1:0]   sc;
      repeat (3) @(negedge clk);
      sw = cfg_width;
      sc = cfg_cin_grp;
      cfg_width = DIMW'(2);
      cfg_cin_grp = GW'(3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cfg_width = sw;
      cfg_cin_grp = sc;
   endtask

   task automatic run_case(int k);
      @(negedge clk);
      cfg_width    = DIMW'(CASES[k][0]);
      cfg_height   = DIMW'(CASES[k][1]);
      cfg_cin_grp  = GW'(CASES[k][2]);
      cfg_cout_grp = GW'(CASES[k][3]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      fork
         feed_act(CASES[k][0], CASES[k][1], CASES[k][2], CASES[k][3], CASES[k][4], k);
         feed_wgt(CASES[k][0], CASES[k][1], CASES[k][2], CASES[k][3], CASES[k][4], k);
         drain(CASES[k][0], CASES[k][1], CASES[k][2], CASES[k][3], CASES[k][4], k,
               CASES[k][5] != 0);
         begin
            if (CASES[k][5] != 0) restart_try();
         end
      join
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1 check(!out_valid && !act_ready && !wgt_ready && !done, "R1", "reset state",
               OW'({out_valid, act_ready, wgt_ready, done}), '0);
      act_valid = 1'b1;
      wgt_valid = 1'b1;
      for (int n = 0; n < 3; n++) begin
         @(negedge clk);
         #1 check(!act_ready && !wgt_ready, "R10", "ready while idle",
                  OW'({act_ready, wgt_ready}), '0);
      end
      act_valid = 1'b0;
      wgt_valid = 1'b0;
      for (int k = 0; k < NCASE; k++) run_case(k);
      act_valid = 1'b1;
      wgt_valid = 1'b1;
      @(negedge clk);
      #1 check(!act_ready && !wgt_ready && !out_valid, "R10", "ready after run",
               OW'({act_ready, wgt_ready, out_valid}), '0);
      act_valid = 1'b0;
      wgt_valid = 1'b0;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog: actual run still active, expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule